// File: doc/BRIEF.md
# Dual-Channel Audio Sample FIFO with Shared Interrupt Status

This block buffers byte-wide audio samples for a two-channel sound engine. Each channel (A and B) owns a 1024-byte ring buffer. The host fills it through a write port, and a playback strobe drains one byte from each channel per sample period. A channel with no data plays the silence value 0x80. Each channel keeps two sticky status bits: one shows the buffer is at or below half full, the other shows it has just reached full or empty. The two channels share one 4-bit status register that clears when it is read. A single level interrupt is raised by threshold crossings and lowered by a status read or by a clear.

A 2-bit operating mode selects the behaviour. In FIFO mode (mode = 1), host writes are pushed in order. In every other mode a host write goes straight to the addressed byte of the chosen channel's storage, and any byte can be read back through a read port. Two actions reset both FIFOs: a software clear strobe, and any change of the mode value. When both FIFOs stay empty for 1024 consecutive sample periods in FIFO mode, every status bit is set and the interrupt fires. This repeats every 1024 periods for as long as the FIFOs stay idle, so a driver that leaves playback running still gets periodic interrupts.

Top module: `afifo_pair`

## Requirements
- R1: Each channel stores 1024 bytes in ring order. Bytes pushed in FIFO mode come out on the playback strobe in the order they were pushed, including across the wrap of the 10-bit pointers.
- R2: After every accepted push or pop on a channel, that channel's half bit is set when the resulting count is 511 or less, and cleared otherwise.
- R3: When the channel's half-interrupt enable is set, the interrupt rises on a push that brings the count to exactly 512, and on a pop that brings it to exactly 511. When the enable is clear, neither event raises it.
- R4: A push that brings the count to 1023 sets the channel's full/empty bit and raises the interrupt. A push arriving at count 1023 with no pop in the same cycle is dropped and changes nothing.
- R5: A pop that brings the count to 0 sets the channel's full/empty bit and raises the interrupt.
- R6: A status read loads stat_o, in the next cycle, with the pre-read value {B full/empty, B half, A full/empty, A half} in bits 3:0. It clears all four bits and lowers the interrupt. An event in the same cycle as the read is kept, and the interrupt stays high.
- R7: A clear strobe, or a mode write whose value differs from the current mode, zeroes both channels' pointers, counts and status and lowers the interrupt. A mode write of the same value changes nothing.
- R8: In FIFO mode a host write is pushed at the write pointer. In any other mode it goes to byte wr_addr_i of the selected channel, touches no count or status, and can be read on rd_data_o one cycle after rd_addr_i is presented.
- R9: In FIFO mode, on the 1024th consecutive playback strobe with both FIFOs empty, all four status bits are set and the interrupt rises. The count restarts, so this repeats every 1024 strobes while both stay empty.
- R10: A playback strobe on an empty channel outputs 0x80 and leaves that channel's count and status unchanged.
- R11: With parameter BASIC_VARIANT = 1, both half-interrupt enables are 1 after reset.
- R12: A push and a pop in the same cycle on a non-empty channel leave the count unchanged, re-evaluate the half bit against that count, and raise no interrupt.
- R13: The sample outputs are registered. A popped byte appears in the cycle after the strobe edge, not combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 2 | New mode value (1 = FIFO mode) |
| ctl_clear_i | input | 1 | Software clear of both FIFOs |
| hen_we_i | input | 1 | Half-interrupt enable write strobe |
| hen_wdata_i | input | 2 | Enables, bit 0 = A, bit 1 = B |
| wr_en_i | input | 1 | Host byte write |
| wr_chan_i | input | 1 | Write channel, 0 = A, 1 = B |
| wr_addr_i | input | AW | Byte address for direct writes |
| wr_data_i | input | 8 | Write data |
| rd_chan_i | input | 1 | Read-port channel |
| rd_addr_i | input | AW | Read-port byte address |
| rd_data_o | output | 8 | Stored byte, one cycle later |
| play_tick_i | input | 1 | Sample-period strobe, pops both channels |
| smp_a_o | output | 8 | Channel A sample |
| smp_b_o | output | 8 | Channel B sample |
| stat_rd_i | input | 1 | Status read strobe |
| stat_o | output | 4 | Captured status from the last read |
| irq_o | output | 1 | Level interrupt |

## Verification
Two states are the hardest to reach from the ports: the repeating idle interrupt, and the full threshold at 1023 entries. Both need long runs of quiet stimulus in which nothing else may happen. The bench fills channel A one byte at a time up to 1023, and after every push it reads the status and compares it with values computed from the running count. It then drains the channel the same way, so every threshold is swept in both directions. For the idle case, the bench first clears both FIFOs and then holds the playback strobe for exactly 1023 cycles. It confirms the interrupt is still silent, then gives one more strobe and expects all four bits. The whole sequence is repeated to show that the interrupt recurs.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam logic [7:0] SILENCE = 8'h80;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_FIFO = 2'd1,
    MODE_WAVE = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef struct packed {
    logic fe_b;
    logic half_b;
    logic fe_a;
    logic half_a;
  } status_t;
endpackage

// File: rtl/afifo_chan.sv
module afifo_chan
  import afifo_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          stat_clr_i,
  input  logic          idle_set_i,
  input  logic          half_en_i,
  input  logic          fifo_mode_i,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          pop_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o,
  output logic [7:0]    smp_o,
  output logic          half_o,
  output logic          fe_o,
  output logic          empty_o,
  output logic          evt_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] CNT_FULL = AW'(DEPTH - 1);
  localparam logic [AW-1:0] CNT_HALF = AW'(DEPTH / 2);
  localparam logic [AW-1:0] CNT_HALF_M1 = AW'(DEPTH / 2 - 1);

  function automatic logic [AW-1:0] count_step(input logic [AW-1:0] c,
                                               input logic up, input logic dn);
    case ({up, dn})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  function automatic logic below_half(input logic [AW-1:0] c);
    return c <= CNT_HALF_M1;
  endfunction

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr, cnt, cnt_nxt;
  logic          half_q, fe_q, half_nxt, fe_nxt;
  logic          push_req, pop_ok, push_ok, push_only, pop_only;
  logic          evt_half, evt_fe;

  assign push_req  = wr_i & fifo_mode_i;
  assign pop_ok    = pop_i & (cnt != '0);
  assign push_ok   = push_req & ((cnt != CNT_FULL) | pop_ok);
  assign push_only = push_ok & ~pop_ok;
  assign pop_only  = pop_ok & ~push_ok;
  assign cnt_nxt   = count_step(cnt, push_ok, pop_ok);

  assign evt_half = half_en_i & ((push_only & (cnt_nxt == CNT_HALF)) |
                                 (pop_only & (cnt_nxt == CNT_HALF_M1)));
  assign evt_fe   = (push_only & (cnt_nxt == CNT_FULL)) |
                    (pop_only & (cnt_nxt == '0));
  assign evt_o    = evt_half | evt_fe;

  always_comb begin
    half_nxt = stat_clr_i ? 1'b0 : half_q;
    fe_nxt   = stat_clr_i ? 1'b0 : fe_q;
    if (push_ok | pop_ok) half_nxt = below_half(cnt_nxt);
    if (evt_fe) fe_nxt = 1'b1;
    if (idle_set_i) begin
      half_nxt = 1'b1;
      fe_nxt   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!clr_i) begin
      if (push_ok) mem[wptr] <= wdata_i;
      else if (wr_i && !fifo_mode_i) mem[waddr_i] <= wdata_i;
    end
    rdata_o <= mem[raddr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      half_q <= 1'b0;
      fe_q   <= 1'b0;
      smp_o  <= SILENCE;
    end else if (clr_i) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      half_q <= 1'b0;
      fe_q   <= 1'b0;
      smp_o  <= SILENCE;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok) rptr <= rptr + 1'b1;
      cnt    <= cnt_nxt;
      half_q <= half_nxt;
      fe_q   <= fe_nxt;
      if (pop_i) smp_o <= pop_ok ? mem[rptr] : SILENCE;
    end
  end

  assign half_o  = half_q;
  assign fe_o    = fe_q;
  assign empty_o = (cnt == '0);

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_i && cnt == CNT_FULL && !clr_i) |=> (cnt == CNT_FULL));
  assert_full_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_only && cnt == CNT_FULL - 1'b1 && !clr_i && !idle_set_i) |=> fe_q);
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && cnt == '0 && !wr_i && !clr_i) |=> (cnt == '0 && smp_o == SILENCE));
  assert_clear_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt == '0 && !half_q && !fe_q && wptr == rptr));
  assert_push_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok && !clr_i) |=> $stable(cnt));
endmodule

// File: rtl/afifo_idle.sv
module afifo_idle #(
  parameter int AW = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic idle_i,
  output logic fire_o
);
  localparam logic [AW-1:0] LAST = AW'((1 << AW) - 1);

  logic [AW-1:0] span;

  assign fire_o = run_i & tick_i & idle_i & (span == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) span <= '0;
    else if (clr_i || !run_i || !idle_i || fire_o) span <= '0;
    else if (tick_i) span <= span + 1'b1;
  end

  assert_idle_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !clr_i) |=> (span == '0));
endmodule

// File: rtl/afifo_pair.sv
module afifo_pair
  import afifo_pkg::*;
#(
  parameter int AW            = 10,
  parameter bit BASIC_VARIANT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we_i,
  input  logic [1:0]    mode_wdata_i,
  input  logic          ctl_clear_i,
  input  logic          hen_we_i,
  input  logic [1:0]    hen_wdata_i,
  input  logic          wr_en_i,
  input  logic          wr_chan_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_chan_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  input  logic          play_tick_i,
  output logic [7:0]    smp_a_o,
  output logic [7:0]    smp_b_o,
  input  logic          stat_rd_i,
  output logic [3:0]    stat_o,
  output logic          irq_o
);
  localparam int NCH = 2;

  mode_e          mode_q;
  logic [NCH-1:0] hen_q, half, fe, empty, evt;
  logic [7:0]     smp  [NCH];
  logic [7:0]     rdat [NCH];
  logic           fifo_mode, clr_all, idle_fire, evt_any, rd_chan_q;
  status_t        cur;

  assign fifo_mode = (mode_q == MODE_FIFO);
  assign clr_all   = ctl_clear_i | (mode_we_i & (mode_wdata_i != mode_q));

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    afifo_chan #(.AW(AW)) i_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr_all),
      .stat_clr_i (stat_rd_i),
      .idle_set_i (idle_fire),
      .half_en_i  (hen_q[g]),
      .fifo_mode_i(fifo_mode),
      .wr_i       (wr_en_i && (wr_chan_i == 1'(g))),
      .waddr_i    (wr_addr_i),
      .wdata_i    (wr_data_i),
      .pop_i      (play_tick_i & fifo_mode),
      .raddr_i    (rd_addr_i),
      .rdata_o    (rdat[g]),
      .smp_o      (smp[g]),
      .half_o     (half[g]),
      .fe_o       (fe[g]),
      .empty_o    (empty[g]),
      .evt_o      (evt[g])
    );
  end

  afifo_idle #(.AW(AW)) i_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_all),
    .run_i (fifo_mode),
    .tick_i(play_tick_i),
    .idle_i(&empty),
    .fire_o(idle_fire)
  );

  assign evt_any = (|evt) | idle_fire;
  assign cur = '{fe_b: fe[1], half_b: half[1], fe_a: fe[0], half_a: half[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_OFF;
      hen_q     <= {NCH{BASIC_VARIANT}};
      stat_o    <= '0;
      irq_o     <= 1'b0;
      rd_chan_q <= 1'b0;
    end else begin
      rd_chan_q <= rd_chan_i;
      if (mode_we_i) mode_q <= mode_e'(mode_wdata_i);
      if (hen_we_i) hen_q <= hen_wdata_i;
      if (stat_rd_i) stat_o <= cur;
      if (clr_all) irq_o <= 1'b0;
      else if (evt_any) irq_o <= 1'b1;
      else if (stat_rd_i) irq_o <= 1'b0;
    end
  end

  assign smp_a_o   = smp[0];
  assign smp_b_o   = smp[1];
  assign rd_data_o = rdat[rd_chan_q];

  assert_read_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !evt_any && !clr_all) |=> !irq_o);
  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_any && !clr_all) |=> irq_o);
  assert_clear_lowers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (!irq_o && !(|half) && !(|fe)));
  assert_idle_all_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_fire && !clr_all) |=> (&half && &fe));
endmodule

// File: tb/test_afifo_pair.sv
`timescale 1ns/1ps
module test_afifo_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 0, ctl_clear = 0, hen_we = 0, wr_en = 0, wr_chan = 0;
  logic [1:0] mode_wdata = 0, hen_wdata = 0;
  logic [9:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic       rd_chan = 0, play_tick = 0, stat_rd = 0;
  logic [7:0] rd_data, smp_a, smp_b;
  logic [3:0] stat, s;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  afifo_pair i_afifo_pair (
    .clk(clk), .rst_n(rst_n), .mode_we_i(mode_we), .mode_wdata_i(mode_wdata),
    .ctl_clear_i(ctl_clear), .hen_we_i(hen_we), .hen_wdata_i(hen_wdata),
    .wr_en_i(wr_en), .wr_chan_i(wr_chan), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_chan_i(rd_chan), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .play_tick_i(play_tick), .smp_a_o(smp_a), .smp_b_o(smp_b),
    .stat_rd_i(stat_rd), .stat_o(stat), .irq_o(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 7 + 3) & 255);
  endfunction

  task automatic push(input logic ch, input logic [7:0] d);
    wr_en = 1; wr_chan = ch; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic tick();
    play_tick = 1;
    @(negedge clk);
    play_tick = 0;
  endtask

  task automatic read_stat(output logic [3:0] v);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    v = stat;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_we = 1; mode_wdata = m;
    @(negedge clk);
    mode_we = 0;
  endtask

  task automatic clear_all();
    ctl_clear = 1;
    @(negedge clk);
    ctl_clear = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 reset irq", irq, 0);
    check("R6 reset stat", stat, 0);
    check("R10 reset smp", smp_a, 8'h80);
    set_mode(2'd1);

    // fill A to 1023; reset enables are 1 (R11)
    for (int n = 1; n <= 1023; n++) begin
      push(0, pat(n));
      check("R3 R4 R11 irq on push", irq, (n == 512 || n == 1023));
      read_stat(s);
      check("R2 half on push", s[0], (n <= 511));
      check("R4 full flag", s[1], (n == 1023));
      check("R2 B untouched", s[3:2], 0);
    end
    push(0, 8'hEE);
    check("R4 dropped push irq", irq, 0);
    read_stat(s);
    check("R4 dropped push stat", s, 0);

    // drain A; B is empty throughout
    for (int k = 1; k <= 1023; k++) begin
      int c;
      c = 1023 - k;
      tick();
      check("R1 R13 order", smp_a, pat(k));
      check("R10 B silence", smp_b, 8'h80);
      check("R3 R5 irq on pop", irq, (c == 511 || c == 0));
      read_stat(s);
      check("R2 half on pop", s[0], (c <= 511));
      check("R5 empty flag", s[1], (c == 0));
      check("R10 B status", s[3:2], 0);
    end
    tick();
    check("R10 empty pop", smp_a, 8'h80);
    check("R10 empty irq", irq, 0);
    read_stat(s);
    check("R10 empty stat", s, 0);

    // wrap of pointers
    for (int i = 0; i < 4; i++) push(0, 8'hA0 + 8'(i));
    play_tick = 1;
    #1 check("R13 not combinational", smp_a, 8'h80);
    @(negedge clk);
    play_tick = 0;
    check("R1 wrap 0", smp_a, 8'hA0);
    for (int i = 1; i < 4; i++) begin
      tick();
      check("R1 wrap", smp_a, 8'hA0 + 8'(i));
    end
    read_stat(s);

    // read in the same cycle as an event
    push(0, 8'h11);
    read_stat(s);
    stat_rd = 1; play_tick = 1;
    @(negedge clk);
    stat_rd = 0; play_tick = 0;
    check("R6 event wins irq", irq, 1);
    check("R6 pre-read value", stat, 0);
    read_stat(s);
    check("R6 bit order", s, 4'b0011);
    check("R6 read lowers irq", irq, 0);

    // B half interrupt disabled
    hen_we = 1; hen_wdata = 2'b01;
    @(negedge clk);
    hen_we = 0;
    for (int n = 1; n <= 512; n++) push(1, 8'(n));
    check("R3 disabled no irq", irq, 0);
    for (int n = 513; n <= 1023; n++) push(1, 8'(n));
    check("R4 full irq without enable", irq, 1);
    read_stat(s);
    check("R4 B full bits", s, 4'b1000);
    clear_all();
    check("R7 clear irq", irq, 0);
    read_stat(s);
    check("R7 clear stat", s, 0);
    tick();
    check("R7 clear empties B", smp_b, 8'h80);

    // simultaneous push and pop
    hen_we = 1; hen_wdata = 2'b11;
    @(negedge clk);
    hen_we = 0;
    clear_all();
    for (int n = 1; n <= 512; n++) push(0, 8'(n));
    read_stat(s);
    wr_en = 1; wr_chan = 0; wr_data = 8'h55; play_tick = 1;
    @(negedge clk);
    wr_en = 0; play_tick = 0;
    check("R12 no irq at 512", irq, 0);
    check("R12 data", smp_a, 8'd1);
    read_stat(s);
    check("R12 half clear at 512", s, 0);
    tick();
    check("R3 pop to 511 irq", irq, 1);
    read_stat(s);
    wr_en = 1; wr_data = 8'h56; play_tick = 1;
    @(negedge clk);
    wr_en = 0; play_tick = 0;
    check("R12 no irq at 511", irq, 0);
    check("R12 data 3", smp_a, 8'd3);
    read_stat(s);
    check("R12 half set at 511", s, 4'b0001);
    clear_all();

    // mode writes
    push(0, 8'h77);
    set_mode(2'd1);
    tick();
    check("R7 same mode keeps data", smp_a, 8'h77);
    push(0, 8'h66);
    set_mode(2'd2);
    set_mode(2'd1);
    tick();
    check("R7 mode change clears", smp_a, 8'h80);
    check("R7 mode change irq", irq, 0);

    // direct writes
    set_mode(2'd2);
    wr_en = 1; wr_chan = 1; wr_addr = 10'd10; wr_data = 8'h3C;
    @(negedge clk);
    wr_chan = 0; wr_data = 8'hC3;
    @(negedge clk);
    wr_en = 0;
    check("R8 direct no irq", irq, 0);
    rd_chan = 1; rd_addr = 10'd10;
    @(negedge clk);
    check("R8 direct B", rd_data, 8'h3C);
    rd_chan = 0;
    @(negedge clk);
    check("R8 direct A", rd_data, 8'hC3);
    read_stat(s);
    check("R8 direct no status", s, 0);
    set_mode(2'd1);
    push(0, 8'h99);
    rd_addr = 10'd0;
    @(negedge clk);
    check("R8 push lands at pointer", rd_data, 8'h99);
    clear_all();
    read_stat(s);

    // idle interrupt, twice
    for (int rep = 0; rep < 2; rep++) begin
      play_tick = 1;
      repeat (1023) @(negedge clk);
      play_tick = 0;
      check("R9 not before 1024", irq, 0);
      tick();
      check("R9 idle irq", irq, 1);
      read_stat(s);
      check("R9 idle bits", s, 4'hF);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule